// File: doc/BRIEF.md
# Pipeline Hazard Detection Unit

This block sits beside the operand-read stage of a five-stage, in-order, fully predicated pipeline. Each cycle it compares the source register indices of the instruction being read in stage 2 with the destinations of the three older instructions in stages 3, 4 and 5. Results are computed in stage 3 but reach the register file only in stage 5, so each of those three stages may still hold a value that the register file does not yet have. For every source operand the unit returns a 2-bit bypass select, which the operand multiplexers use to take the newest in-flight value in place of the register file read.

Jumps are predicated like every other instruction. A compare writes the predicate file, and no forwarding path exists for predicates. So when the read stage holds a jump whose predicate is the target of a compare that is still in stages 3 to 5, the unit raises a stall. The stall freezes stages 1 and 2 and puts a bubble into stage 3 until the compare has left the pipe. An older instruction whose predicate resolved false, or which does not write, takes no part in either check. The outputs are combinational, so they apply in the same cycle as the inputs that cause them.

Top module: `hz_detect_unit`

## Requirements
- R1: When a used source index equals the destination of an active writer in stage 3, that operand's select is 1 (stage-3 result).
- R2: When the only active writer matching a used source is in stage 4, the select is 2 (stage-4 result).
- R3: When the only active writer matching a used source is in stage 5, the select is 3 (stage-5 result). The select is therefore independent of any write-first behaviour inside the register file.
- R4: When several stages match one source, the lowest stage number wins: stage 3 over stage 4 over stage 5.
- R5: A source that matches no active writer, or whose use flag is low, gets select 0 (register file).
- R6: A writer counts as active only when its write-enable and its predicate-true flag are both high. A squashed or non-writing instruction never selects a bypass.
- R7: A jump in stage 2 whose predicate index equals the destination of an active compare (compare flag and predicate-true both high) in stage 3, 4 or 5 asserts stall and bubble. Both remain high for as long as such a compare is present.
- R8: No stall arises from a compare that writes a different predicate, from a squashed compare, or when the read-stage instruction is not a jump.
- R9: A register dependence alone never asserts stall. Bubble always equals stall.
- R10: Each source operand is resolved on its own. Operand k uses bits [2k+1:2k] of the select bus and bits [5k+4:5k] of the index bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_src_idx | input | 10 | Source register indices of the stage-2 instruction, 5 bits per operand |
| rd_src_use | input | 2 | Per-operand flag: the operand is actually read |
| rd_is_jmp | input | 1 | Stage-2 instruction is a jump |
| rd_jmp_pidx | input | 3 | Predicate index the jump tests |
| old_dst_idx | input | 15 | Destination register of stages 3, 4, 5 (5 bits each, stage 3 lowest) |
| old_wr_en | input | 3 | Register write-enable of stages 3, 4, 5 (bit 0 = stage 3) |
| old_pred_ok | input | 3 | Predicate resolved true for stages 3, 4, 5 |
| old_is_cmp | input | 3 | Stage holds a predicate-writing compare |
| old_cmp_pidx | input | 9 | Predicate destination of stages 3, 4, 5 (3 bits each) |
| byp_sel | output | 4 | Bypass select per operand: 0 regfile, 1 stage 3, 2 stage 4, 3 stage 5 |
| stall | output | 1 | Freeze stages 1 and 2 |
| bubble | output | 1 | Insert an empty slot into stage 3 |

## Verification
The register path is tried with a producer placed alone in each of stages 3, 4 and 5, then with two and three producers of the same register at once. The single-producer cases check the select encoding. The multi-producer cases separate correct youngest-first priority from reversed or missing priority. Squashed and non-writing producers are placed on matching indices to show that both the write-enable and the predicate-true gates are applied. Mixed-operand patterns show that each operand is resolved on its own. The predicate interlock is followed cycle by cycle as a compare moves from stage 3 to stage 5 and then leaves, with a wrong-index compare, a squashed compare and a non-jump reader as negative cases.

// File: rtl/hz_pkg.sv
// Package hz_pkg
// Shared constants and types of the hazard detection unit.
// Assumes a fixed five-stage pipe whose stages 3, 4 and 5 may hold
// results that the register file does not have yet.
package hz_pkg;

    // Number of older stages that are compared with the read stage (3, 4, 5)
    localparam int unsigned NCHK = 3;

    // Operand source choice; the value equals (stage number - 2) for bypasses
    typedef enum logic [1:0] {
        BYP_RF  = 2'd0,
        BYP_EX  = 2'd1,
        BYP_MEM = 2'd2,
        BYP_WB  = 2'd3
    } byp_sel_e;

endpackage

// File: rtl/hz_src_match.sv
// Module hz_src_match
// Resolves one source operand: it compares the index with each older
// stage's destination and picks the youngest active producer.
// Assumes wr_act is already qualified by write-enable and predicate.
module hz_src_match
    import hz_pkg::*;
#(
    parameter int unsigned RAW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [RAW-1:0]       src_idx,
    input  logic                 src_use,
    input  logic [NCHK*RAW-1:0]  dst_idx,
    input  logic [NCHK-1:0]      wr_act,
    output byp_sel_e             sel
);

    logic [NCHK-1:0] hit;

    // Per-stage index comparison, gated by operand use and writer activity
    generate
        for (genvar s = 0; s < NCHK; s++) begin : g_cmp
            assign hit[s] = src_use && wr_act[s] &&
                            (dst_idx[s*RAW +: RAW] == src_idx);
        end
    endgenerate

    // Priority pick: scan from the oldest stage, so the youngest hit wins
    always_comb begin
        sel = BYP_RF;
        for (int i = NCHK - 1; i >= 0; i--) begin
            if (hit[i]) sel = byp_sel_e'(i + 1);
        end
    end

    AST_YOUNGEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_use && wr_act[0] && dst_idx[RAW-1:0] == src_idx) |-> sel == BYP_EX); // R4
    AST_NO_WRITER_RF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_act == '0 || !src_use) |-> sel == BYP_RF); // R5
    AST_BYP_HAS_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != BYP_RF) |-> wr_act[sel - 1]); // R6

endmodule

// File: rtl/hz_pred_lock.sv
// Module hz_pred_lock
// Predicate interlock: it flags a read-stage jump whose predicate is
// still to be written by an active compare in stages 3 to 5.
// Assumes the predicate file has no forwarding path and is up to date
// once the compare has left stage 5.
module hz_pred_lock
    import hz_pkg::*;
#(
    parameter int unsigned PAW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 jmp,
    input  logic [PAW-1:0]       jmp_pidx,
    input  logic [NCHK-1:0]      cmp_act,
    input  logic [NCHK*PAW-1:0]  cmp_pidx,
    output logic                 lock
);

    logic [NCHK-1:0] pend;

    // Per-stage check for a compare that writes the jump's predicate
    generate
        for (genvar s = 0; s < NCHK; s++) begin : g_pend
            assign pend[s] = cmp_act[s] && (cmp_pidx[s*PAW +: PAW] == jmp_pidx);
        end
    endgenerate

    // Lock when the read stage holds a jump and any matching compare is in flight
    always_comb begin
        lock = jmp && (|pend);
    end

    AST_LOCK_NEEDS_JMP: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> jmp); // R8
    AST_LOCK_NEEDS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> (|cmp_act)); // R8

endmodule

// File: rtl/hz_detect_unit.sv
// Module hz_detect_unit
// Top of the hazard detection unit. It forms the active-writer masks of
// stages 3 to 5, resolves one bypass select per source operand and
// raises stall/bubble for predicate hazards on jumps.
// Assumes stage-5 writes land at the clock edge that ends stage 5.
module hz_detect_unit
    import hz_pkg::*;
#(
    parameter int unsigned NSRC = 2,
    parameter int unsigned RAW  = 5,
    parameter int unsigned PAW  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC*RAW-1:0]   rd_src_idx,
    input  logic [NSRC-1:0]       rd_src_use,
    input  logic                  rd_is_jmp,
    input  logic [PAW-1:0]        rd_jmp_pidx,
    input  logic [NCHK*RAW-1:0]   old_dst_idx,
    input  logic [NCHK-1:0]       old_wr_en,
    input  logic [NCHK-1:0]       old_pred_ok,
    input  logic [NCHK-1:0]       old_is_cmp,
    input  logic [NCHK*PAW-1:0]   old_cmp_pidx,
    output logic [NSRC*2-1:0]     byp_sel,
    output logic                  stall,
    output logic                  bubble
);

    logic [NCHK-1:0] wr_act;
    logic [NCHK-1:0] cmp_act;
    logic            lock;

    // Qualify older stages: a squashed instruction neither writes nor compares
    always_comb begin
        wr_act  = old_wr_en  & old_pred_ok;
        cmp_act = old_is_cmp & old_pred_ok;
    end

    // One resolver per source operand
    generate
        for (genvar k = 0; k < NSRC; k++) begin : g_src
            byp_sel_e sel_k;
            hz_src_match #(.RAW(RAW)) u_match (
                .clk     (clk),
                .rst_n   (rst_n),
                .src_idx (rd_src_idx[k*RAW +: RAW]),
                .src_use (rd_src_use[k]),
                .dst_idx (old_dst_idx),
                .wr_act  (wr_act),
                .sel     (sel_k)
            );
            assign byp_sel[k*2 +: 2] = sel_k;
        end
    endgenerate

    hz_pred_lock #(.PAW(PAW)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .jmp      (rd_is_jmp),
        .jmp_pidx (rd_jmp_pidx),
        .cmp_act  (cmp_act),
        .cmp_pidx (old_cmp_pidx),
        .lock     (lock)
    );

    // Stall freezes stages 1-2; bubble empties stage 3 in the same cycle
    always_comb begin
        stall  = lock;
        bubble = lock;
    end

    AST_BUBBLE_EQ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        bubble == stall); // R9
    AST_NO_REG_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_is_jmp |-> !stall); // R9
    AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stall) && rd_is_jmp && $stable(rd_jmp_pidx) && $stable(old_is_cmp)
         && $stable(old_cmp_pidx) && $stable(old_pred_ok)) |-> stall); // R7

endmodule

// File: tb/hz_detect_unit_tb.sv
module hz_detect_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  rd_src_idx = '0;
    logic [1:0]  rd_src_use = '0;
    logic        rd_is_jmp = 1'b0;
    logic [2:0]  rd_jmp_pidx = '0;
    logic [14:0] old_dst_idx = '0;
    logic [2:0]  old_wr_en = '0;
    logic [2:0]  old_pred_ok = '0;
    logic [2:0]  old_is_cmp = '0;
    logic [8:0]  old_cmp_pidx = '0;
    logic [3:0]  byp_sel;
    logic        stall;
    logic        bubble;

    int n_run = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    hz_detect_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd_src_idx(rd_src_idx), .rd_src_use(rd_src_use),
        .rd_is_jmp(rd_is_jmp), .rd_jmp_pidx(rd_jmp_pidx),
        .old_dst_idx(old_dst_idx), .old_wr_en(old_wr_en),
        .old_pred_ok(old_pred_ok), .old_is_cmp(old_is_cmp),
        .old_cmp_pidx(old_cmp_pidx),
        .byp_sel(byp_sel), .stall(stall), .bubble(bubble)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    // drive at negedge, then sample one nanosecond later (outputs are combinational)
    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic idle();
        rd_src_idx = '0; rd_src_use = '0; rd_is_jmp = 1'b0; rd_jmp_pidx = '0;
        old_dst_idx = '0; old_wr_en = '0; old_pred_ok = '0;
        old_is_cmp = '0; old_cmp_pidx = '0;
    endtask

    task automatic put(input int s, input int dst, input bit we, input bit ok,
                       input bit cmp, input int pd);
        old_dst_idx[s*5 +: 5]  = 5'(dst);
        old_wr_en[s]           = we;
        old_pred_ok[s]         = ok;
        old_is_cmp[s]          = cmp;
        old_cmp_pidx[s*3 +: 3] = 3'(pd);
    endtask

    task automatic src(input int a, input bit ua, input int b, input bit ub);
        rd_src_idx = {5'(b), 5'(a)};
        rd_src_use = {ub, ua};
    endtask

    task automatic t_reset();
        idle();
        settle();
        chk("R5 reset sel", int'(byp_sel), 0);
        chk("R9 reset stall", int'(stall), 0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_single();
        idle(); src(7, 1, 0, 0);
        put(0, 7, 1, 1, 0, 0); settle();
        chk("R1 stage3 sel", int'(byp_sel[1:0]), 1);
        idle(); src(7, 1, 0, 0);
        put(1, 7, 1, 1, 0, 0); settle();
        chk("R2 stage4 sel", int'(byp_sel[1:0]), 2);
        idle(); src(7, 1, 0, 0);
        put(2, 7, 1, 1, 0, 0); settle();
        chk("R3 stage5 sel", int'(byp_sel[1:0]), 3);
        chk("R9 no reg stall", int'(stall), 0);
    endtask

    task automatic t_priority();
        idle(); src(12, 1, 0, 0);
        put(0, 12, 1, 1, 0, 0); put(1, 12, 1, 1, 0, 0); put(2, 12, 1, 1, 0, 0);
        settle();
        chk("R4 all three", int'(byp_sel[1:0]), 1);
        put(0, 3, 1, 1, 0, 0); settle();
        chk("R4 stage4 over 5", int'(byp_sel[1:0]), 2);
        put(0, 12, 1, 1, 0, 0); put(1, 4, 1, 1, 0, 0); settle();
        chk("R4 stage3 over 5", int'(byp_sel[1:0]), 1);
    endtask

    task automatic t_gating();
        idle(); src(9, 1, 0, 0);
        put(0, 9, 1, 0, 0, 0); put(1, 9, 0, 1, 0, 0); settle();
        chk("R6 squashed and no-we", int'(byp_sel[1:0]), 0);
        put(2, 9, 1, 1, 0, 0); settle();
        chk("R6 skip to stage5", int'(byp_sel[1:0]), 3);
        src(9, 0, 0, 0); settle();
        chk("R5 unused operand", int'(byp_sel[1:0]), 0);
        src(10, 1, 0, 0); settle();
        chk("R5 no match", int'(byp_sel[1:0]), 0);
    endtask

    task automatic t_operands();
        idle(); src(5, 1, 6, 1);
        put(0, 6, 1, 1, 0, 0); put(1, 5, 1, 1, 0, 0); settle();
        chk("R10 op0", int'(byp_sel[1:0]), 2);
        chk("R10 op1", int'(byp_sel[3:2]), 1);
        src(6, 1, 31, 1); put(2, 31, 1, 1, 0, 0); settle();
        chk("R10 op0 b", int'(byp_sel[1:0]), 1);
        chk("R10 op1 b", int'(byp_sel[3:2]), 3);
    endtask

    task automatic t_pred_walk();
        idle(); rd_is_jmp = 1'b1; rd_jmp_pidx = 3'd5;
        for (int s = 0; s < 3; s++) begin
            idle(); rd_is_jmp = 1'b1; rd_jmp_pidx = 3'd5;
            put(s, 0, 0, 1, 1, 5); settle();
            chk("R7 stall in flight", int'(stall), 1);
            chk("R9 bubble tracks", int'(bubble), 1);
        end
        idle(); rd_is_jmp = 1'b1; rd_jmp_pidx = 3'd5; settle();
        chk("R7 released", int'(stall), 0);
    endtask

    task automatic t_pred_neg();
        idle(); rd_is_jmp = 1'b1; rd_jmp_pidx = 3'd2;
        put(0, 0, 0, 1, 1, 3); settle();
        chk("R8 other pred", int'(stall), 0);
        put(0, 0, 0, 0, 1, 2); settle();
        chk("R8 squashed cmp", int'(stall), 0);
        put(0, 0, 0, 1, 1, 2); rd_is_jmp = 1'b0; settle();
        chk("R8 not jump", int'(stall), 0);
        chk("R9 bubble low", int'(bubble), 0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_priority();
        t_gating();
        t_operands();
        t_pred_walk();
        t_pred_neg();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++; n_bad++;
            $display("FAIL watchdog got=0 exp=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

endmodule